// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block moves a system out of run mode into one of two low-power states when software writes to one of two register addresses. A write to the idle address stops only the processor clock; everything else keeps running until an interrupt arrives. A write to the standby address also drops the main oscillator enable. Only the address selects the target state, and a request made while an interrupt is pending is silently dropped.

The display controller must be off before standby is entered. A standby request made while the display-enable input is still high is refused, and a one-cycle status pulse reports the refusal. An interrupt in standby first turns the oscillator back on. The processor clock enable then stays low for a programmable number of cycles, which model oscillator settling. The enables are plain registered decodes of the state. The current state is visible on a debug output.

Top module: `lpc_ctrl`

## Requirements
- R1: After the synchronized release of reset, the block is in RUN (state_dbg = 0). osc_en, cpu_clk_en and disp_ok are 1, and stby_blocked is 0.
- R2: In RUN, a write (wr_en = 1) to address 0x800 with irq_pending = 0 gives state_dbg = 1 (IDLE) one cycle later. In IDLE, cpu_clk_en = 0 and osc_en = 1.
- R3: In IDLE, irq_pending = 1 returns the block to RUN one cycle later, with all enables at 1.
- R4: A write to 0x800 or 0x840 while irq_pending = 1 leaves the block in RUN.
- R5: In RUN, a write to 0x840 with irq_pending = 0 and disp_en = 0 gives state_dbg = 2 (STANDBY) one cycle later, with osc_en = 0 and cpu_clk_en = 0.
- R6: A write to 0x840 with irq_pending = 0 and disp_en = 1 leaves the block in RUN. stby_blocked is 1 for exactly the following cycle.
- R7: A write to any address other than 0x800 or 0x840 does not change the state.
- R8: In STANDBY, irq_pending = 1 moves the block to state_dbg = 3 (WAKE) one cycle later, with osc_en = 1 and cpu_clk_en = 0. WAKE lasts SETTLE_CYC cycles, and then the block returns to RUN.
- R9: disp_ok is 1 only in RUN and 0 in IDLE, STANDBY and WAKE.
- R10: Writes made in IDLE, STANDBY or WAKE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases through a synchronizer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (12) | Write address offset in the register window |
| irq_pending | input | 1 | An interrupt is active or pending |
| disp_en | input | 1 | Display controller is currently enabled |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| disp_ok | output | 1 | Display controller may be enabled |
| stby_blocked | output | 1 | One-cycle pulse: standby refused because the display was on |
| state_dbg | output | 2 | State: 0 RUN, 1 IDLE, 2 STANDBY, 3 WAKE |

## Verification
Every result of a write or an interrupt appears one cycle after the clock edge that samples it, because all outputs are decoded from the state register. The one exception is the processor clock returning from standby, which is due SETTLE_CYC cycles after entry to WAKE. The driver changes inputs on the falling edge and queues the value expected after the next rising edge. The monitor pops the queue 2 ns after each rising edge, so every comparison falls exactly one edge after its stimulus. The wake window is checked cycle by cycle, and a write is applied in the middle of it.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_STBY = 2'd2,
    ST_WAKE = 2'd3
  } lpc_state_e;
endpackage

// File: rtl/lpc_rst_sync.sv
module lpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lpc_req_decode.sv
module lpc_req_decode #(
  parameter int ADDR_W   = 12,
  parameter int IDLE_OFS = 'h800,
  parameter int STBY_OFS = 'h840
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              irq_pending,
  input  logic              disp_en,
  output logic              req_idle,
  output logic              req_stby,
  output logic              stby_refused
);
  localparam logic [ADDR_W-1:0] IDLE_A = ADDR_W'(IDLE_OFS);
  localparam logic [ADDR_W-1:0] STBY_A = ADDR_W'(STBY_OFS);

  logic wr_ok;
  logic hit_stby;

  // a pending interrupt cancels any request outright
  assign wr_ok        = wr_en && !irq_pending;
  assign hit_stby     = wr_ok && (wr_addr == STBY_A);
  assign req_idle     = wr_ok && (wr_addr == IDLE_A);
  assign req_stby     = hit_stby && !disp_en;
  assign stby_refused = hit_stby && disp_en;
endmodule

// File: rtl/lpc_settle_timer.sv
module lpc_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign cnt_ce = load || (run && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = LOAD_VAL;
    else if (cnt_ce) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int IDLE_OFS   = 'h800,
  parameter int STBY_OFS   = 'h840,
  parameter int SETTLE_CYC = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              irq_pending,
  input  logic              disp_en,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              disp_ok,
  output logic              stby_blocked,
  output logic [1:0]        state_dbg
);
  logic       rst_n_s;
  logic       req_idle, req_stby, stby_refused;
  logic       tmr_load, tmr_done;
  lpc_state_e state_q, state_d;
  logic       blk_q, blk_d;

  lpc_rst_sync #(.STAGES(SYNC_STG)) rst_sync_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lpc_req_decode #(
    .ADDR_W   (ADDR_W),
    .IDLE_OFS (IDLE_OFS),
    .STBY_OFS (STBY_OFS)
  ) dec_i (
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .irq_pending  (irq_pending),
    .disp_en      (disp_en),
    .req_idle     (req_idle),
    .req_stby     (req_stby),
    .stby_refused (stby_refused)
  );

  lpc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (tmr_load),
    .run   (state_q == ST_WAKE),
    .done  (tmr_done)
  );

  // next-state logic; requests are honoured only in RUN
  always_comb begin
    state_d  = state_q;
    blk_d    = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (req_idle)      state_d = ST_IDLE;
        else if (req_stby) state_d = ST_STBY;
        blk_d = stby_refused;
      end
      ST_IDLE: if (irq_pending) state_d = ST_RUN;
      ST_STBY: begin
        if (irq_pending) begin
          state_d  = ST_WAKE;
          tmr_load = 1'b1;
        end
      end
      ST_WAKE: if (tmr_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_RUN;
      blk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
    end
  end

  assign osc_en       = (state_q != ST_STBY);
  assign cpu_clk_en   = (state_q == ST_RUN);
  assign disp_ok      = (state_q == ST_RUN);
  assign stby_blocked = blk_q;
  assign state_dbg    = state_q;
endmodule

// File: rtl/lpc_ctrl_chk.sv
module lpc_ctrl_chk #(
  parameter int ADDR_W   = 12,
  parameter int IDLE_OFS = 'h800,
  parameter int STBY_OFS = 'h840
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq_pending,
  input logic              disp_en,
  input logic              cpu_clk_en,
  input logic              stby_blocked,
  input logic [1:0]        state_dbg
);
  localparam logic [ADDR_W-1:0] IA = ADDR_W'(IDLE_OFS);
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STBY_OFS);

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_dbg == 2'd0 && wr_en && wr_addr == IA && !irq_pending) |=> (state_dbg == 2'd1));

  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_dbg == 2'd1 && irq_pending) |=> (state_dbg == 2'd0));

  assert_irq_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_dbg == 2'd0 && wr_en && irq_pending) |=> (state_dbg == 2'd0));

  assert_disp_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_dbg == 2'd0 && wr_en && wr_addr == SA && !irq_pending && disp_en)
    |=> (stby_blocked && state_dbg == 2'd0));

  assert_other_addr_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_dbg == 2'd0 && wr_en && wr_addr != IA && wr_addr != SA) |=> (state_dbg == 2'd0));

  assert_clk_return_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(cpu_clk_en) |-> ($past(state_dbg) == 2'd1 || $past(state_dbg) == 2'd3));

  assert_idle_write_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_dbg == 2'd1 && wr_en && !irq_pending) |=> (state_dbg == 2'd1));
endmodule

bind lpc_ctrl lpc_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .IDLE_OFS (IDLE_OFS),
  .STBY_OFS (STBY_OFS)
) chk_i (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .irq_pending  (irq_pending),
  .disp_en      (disp_en),
  .cpu_clk_en   (cpu_clk_en),
  .stby_blocked (stby_blocked),
  .state_dbg    (state_dbg)
);

// File: tb/lpc_ctrl_tb_top.sv
module lpc_ctrl_tb_top;
  localparam int SETTLE = 4;
  localparam logic [11:0] A_IDLE = 12'h800;
  localparam logic [11:0] A_STBY = 12'h840;

  typedef struct {
    logic [1:0] st;
    logic       osc, cpu, ok, blk;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, irq_pending, disp_en;
  logic [11:0] wr_addr;
  logic        osc_en, cpu_clk_en, disp_ok, stby_blocked;
  logic [1:0]  state_dbg;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  lpc_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .irq_pending  (irq_pending),
    .disp_en      (disp_en),
    .osc_en       (osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .disp_ok      (disp_ok),
    .stby_blocked (stby_blocked),
    .state_dbg    (state_dbg)
  );

  task automatic step(input logic we, input logic [11:0] a, input logic irq,
                      input logic de, input logic [1:0] st, input logic osc,
                      input logic cpu, input logic ok, input logic blk,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = a; irq_pending = irq; disp_en = de;
    e.st = st; e.osc = osc; e.cpu = cpu; e.ok = ok; e.blk = blk; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one queued item per clock, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if ({state_dbg, osc_en, cpu_clk_en, disp_ok, stby_blocked} !==
            {e.st, e.osc, e.cpu, e.ok, e.blk}) begin
          n_fail++;
          $display("FAIL %s: got st=%0d osc=%b cpu=%b ok=%b blk=%b, exp st=%0d osc=%b cpu=%b ok=%b blk=%b",
                   e.tag, state_dbg, osc_en, cpu_clk_en, disp_ok, stby_blocked,
                   e.st, e.osc, e.cpu, e.ok, e.blk);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; irq_pending = 1'b0; disp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    //    we  addr    irq de  st  osc cpu ok blk
    step(0, 12'h0,   0, 0, 0, 1, 1, 1, 0, "R1 reset state");
    step(1, A_IDLE,  0, 0, 1, 1, 0, 0, 0, "R2 idle entry");
    step(0, 12'h0,   0, 0, 1, 1, 0, 0, 0, "R9 idle holds, display not ok");
    step(1, A_STBY,  0, 0, 1, 1, 0, 0, 0, "R10 standby write in idle ignored");
    step(0, 12'h0,   1, 0, 0, 1, 1, 1, 0, "R3 irq leaves idle");
    step(1, A_IDLE,  1, 0, 0, 1, 1, 1, 0, "R4 idle request under irq");
    step(1, A_STBY,  1, 0, 0, 1, 1, 1, 0, "R4 standby request under irq");
    step(1, 12'h804, 0, 0, 0, 1, 1, 1, 0, "R7 other address ignored");
    step(1, 12'h000, 0, 0, 0, 1, 1, 1, 0, "R7 address zero ignored");
    step(1, A_STBY,  0, 1, 0, 1, 1, 1, 1, "R6 standby refused, display on");
    step(0, 12'h0,   0, 1, 0, 1, 1, 1, 0, "R6 refusal pulse one cycle");
    step(1, A_STBY,  0, 0, 2, 0, 0, 0, 0, "R5 standby entry");
    step(1, A_IDLE,  0, 0, 2, 0, 0, 0, 0, "R10 idle write in standby ignored");
    step(0, 12'h0,   1, 0, 3, 1, 0, 0, 0, "R8 wake entry");
    step(0, 12'h0,   0, 0, 3, 1, 0, 0, 0, "R8 settling 2");
    step(1, A_STBY,  0, 0, 3, 1, 0, 0, 0, "R10 write during wake ignored");
    step(0, 12'h0,   0, 0, 3, 1, 0, 0, 0, "R8 settling 4");
    step(0, 12'h0,   0, 0, 0, 1, 1, 1, 0, "R8 back in run after settle");
    step(1, A_IDLE,  0, 0, 1, 1, 0, 0, 0, "R2 idle entry again");
    step(0, 12'h0,   1, 0, 0, 1, 1, 1, 0, "R3 second idle exit");
    step(0, 12'h0,   0, 0, 0, 1, 1, 1, 0, "R9 run, display ok");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, exp 0", q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule